// File: doc/BRIEF.md
# Privilege-Filtered Cycle Counter Register

This block holds a 64-bit count of core clock cycles for one hart and exposes it through a single-cycle register read/write port selected by a 12-bit address. The count advances by one on every clock edge unless counting is suppressed. Suppression comes either from a global stop bit or from one of five per-mode stop bits. Each per-mode bit applies only while the hart runs in its own mode: machine, hypervisor-capable supervisor, user, virtual supervisor or virtual user.

The port follows the operand width of the hart. With 64-bit operation selected, address 0xB00 reads and writes all 64 bits. With 32-bit operation selected, the same address reaches only the low word, and address 0xB80 reaches the upper word. A write made in 32-bit operation changes only the word it targets and leaves the other word as it was. A write always overrides the increment of that cycle. Reads are combinational from the stored count.

Top module: `cyc_counter_csr`

## Requirements
- R1: While reset is asserted, and on the first cycles after it with counting suppressed, a read of address 0xB00 returns zero.
- R2: When no write and no suppression applies, the full 64-bit count rises by exactly one per clock edge. This includes a carry from bit 31 into bit 32 and a wrap from all ones to zero.
- R3: Per-mode stop bits hold the count only in their own mode. The privilege code is 2'b11 machine, 2'b01 supervisor, 2'b00 user and 2'b10 reserved. With the virtual flag set, supervisor means virtual supervisor and user means virtual user. Machine mode ignores the virtual flag, and the reserved code is matched by no stop bit.
- R4: The global stop bit holds the count in every mode.
- R5: On a cycle with a write, the count takes the written value and no increment is added in that cycle.
- R6: In 32-bit operation, a write to 0xB00 replaces bits 31:0 with write-data bits 31:0 and keeps bits 63:32.
- R7: In 64-bit operation, a write to 0xB00 replaces all 64 bits.
- R8: In 64-bit operation, a read of 0xB00 returns the full 64-bit count and raises the hit flag.
- R9: In 32-bit operation, 0xB00 reads the low word and 0xB80 reads the upper word, each zero-extended to 64 bits. A write to 0xB80 replaces bits 63:32 with write-data bits 31:0 and keeps bits 31:0.
- R10: Any other address, and 0xB80 in 64-bit operation, gives hit low and read data zero, and a write to it leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write strobe for the addressed register |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for the addressed register, zero when unmapped |
| csr_hit | output | 1 | Address selects a register in the current width |
| xlen64 | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit operation |
| priv | input | 2 | Current privilege code (see R3) |
| virt | input | 1 | Hart is running virtualized |
| halt_all | input | 1 | Global count stop |
| halt_m | input | 1 | Stop while in machine mode |
| halt_hs | input | 1 | Stop while in non-virtual supervisor mode |
| halt_u | input | 1 | Stop while in non-virtual user mode |
| halt_vs | input | 1 | Stop while in virtual supervisor mode |
| halt_vu | input | 1 | Stop while in virtual user mode |

## Verification
The bench sets each stop bit against its own mode and against a neighbouring mode. A decoder that ignored the virtual flag, or applied a stop bit in the wrong mode, would freeze the count where it should run, or the reverse. Half-word writes are checked for the word they must keep. A design that zero-filled or overwrote the other word would show it on the next read of that word. The bench also covers the carry out of bit 31 in 32-bit operation, the wrap from all ones, and a write with counting enabled. A design that added the increment on the write cycle would read back one too high. A design that decoded 0xB80 in 64-bit operation would accept a write there and change the count.

// File: rtl/cyc_csr_pkg.sv
package cyc_csr_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    MODE_M,
    MODE_HS,
    MODE_U,
    MODE_VS,
    MODE_VU,
    MODE_NONE
  } run_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_FULL,
    ACC_LOW,
    ACC_HIGH
  } acc_e;

  typedef struct packed {
    logic all;
    logic m;
    logic hs;
    logic u;
    logic vs;
    logic vu;
  } halt_t;

  // Resolve privilege code plus virtual flag into one running mode.
  function automatic run_mode_e classify_mode(priv_e p, logic v);
    run_mode_e r;
    case (p)
      PRIV_M:  r = MODE_M;
      PRIV_S:  r = v ? MODE_VS : MODE_HS;
      PRIV_U:  r = v ? MODE_VU : MODE_U;
      default: r = MODE_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cyc_inhibit_gate.sv
module cyc_inhibit_gate
  import cyc_csr_pkg::*;
(
  input  halt_t     halt,
  input  priv_e     priv,
  input  logic      virt,
  output run_mode_e mode,
  output logic      mode_stop,
  output logic      inhibit
);

  assign mode = classify_mode(priv, virt);

  always_comb begin
    case (mode)
      MODE_M:  mode_stop = halt.m;
      MODE_HS: mode_stop = halt.hs;
      MODE_U:  mode_stop = halt.u;
      MODE_VS: mode_stop = halt.vs;
      MODE_VU: mode_stop = halt.vu;
      default: mode_stop = 1'b0;
    endcase
  end

  assign inhibit = halt.all | mode_stop;

endmodule

// File: rtl/cyc_addr_decode.sv
module cyc_addr_decode
  import cyc_csr_pkg::*;
#(
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'hB00,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'hB80
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              xlen64,
  output acc_e              acc,
  output logic              hit,
  output logic              wr_fire
);

  always_comb begin
    acc = ACC_NONE;
    if (addr == LO_ADDR) begin
      acc = xlen64 ? ACC_FULL : ACC_LOW;
    end else if (addr == HI_ADDR && !xlen64) begin
      acc = ACC_HIGH;
    end
  end

  assign hit     = (acc != ACC_NONE);
  assign wr_fire = we & hit;

endmodule

// File: rtl/cyc_data_path.sv
module cyc_data_path
  import cyc_csr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] wdata,
  input  acc_e             acc,
  output logic [CNT_W-1:0] wr_value,
  output logic [CNT_W-1:0] rdata
);

  localparam int HALF_W   = CNT_W / 2;
  localparam int NUM_HALF = 2;

  function automatic logic [CNT_W-1:0] zext_half(logic [HALF_W-1:0] h);
    return {{(CNT_W-HALF_W){1'b0}}, h};
  endfunction

  // Per-half merge: each half either keeps its stored bits or takes new ones.
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic              take;
    logic [HALF_W-1:0] src;
    assign take = (acc == ACC_FULL)
               || (acc == ACC_LOW  && h == 0)
               || (acc == ACC_HIGH && h == 1);
    assign src  = (acc == ACC_FULL) ? wdata[h*HALF_W +: HALF_W]
                                    : wdata[HALF_W-1:0];
    assign wr_value[h*HALF_W +: HALF_W] = take ? src : count[h*HALF_W +: HALF_W];
  end

  always_comb begin
    case (acc)
      ACC_FULL: rdata = count;
      ACC_LOW:  rdata = zext_half(count[HALF_W-1:0]);
      ACC_HIGH: rdata = zext_half(count[CNT_W-1:HALF_W]);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/cyc_counter_csr.sv
module cyc_counter_csr
  import cyc_csr_pkg::*;
#(
  parameter int              CNT_W   = 64,
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'hB00,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'hB80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [CNT_W-1:0]  csr_wdata,
  output logic [CNT_W-1:0]  csr_rdata,
  output logic              csr_hit,
  input  logic              xlen64,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              halt_all,
  input  logic              halt_m,
  input  logic              halt_hs,
  input  logic              halt_u,
  input  logic              halt_vs,
  input  logic              halt_vu
);

  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  halt_t            halt;
  run_mode_e        mode;
  logic             mode_stop;
  logic             inhibit;
  acc_e             acc;
  logic             wr_fire;
  logic [CNT_W-1:0] wr_value;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  assign halt = '{all: halt_all, m: halt_m, hs: halt_hs,
                  u: halt_u, vs: halt_vs, vu: halt_vu};

  cyc_inhibit_gate u_gate (
    .halt      (halt),
    .priv      (priv_e'(priv)),
    .virt      (virt),
    .mode      (mode),
    .mode_stop (mode_stop),
    .inhibit   (inhibit)
  );

  cyc_addr_decode #(
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) u_dec (
    .addr    (csr_addr),
    .we      (csr_we),
    .xlen64  (xlen64),
    .acc     (acc),
    .hit     (csr_hit),
    .wr_fire (wr_fire)
  );

  cyc_data_path #(
    .CNT_W (CNT_W)
  ) u_path (
    .count    (count_q),
    .wdata    (csr_wdata),
    .acc      (acc),
    .wr_value (wr_value),
    .rdata    (csr_rdata)
  );

  // Write wins over increment; inhibit only matters without a write.
  always_comb begin
    if (wr_fire)       count_d = wr_value;
    else if (!inhibit) count_d = step(count_q);
    else               count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/cyc_counter_csr_chk.sv
module cyc_counter_csr_chk #(
  parameter int              CNT_W   = 64,
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'hB00,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'hB80
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [CNT_W-1:0]  csr_wdata,
  input logic [CNT_W-1:0]  csr_rdata,
  input logic              csr_hit,
  input logic              xlen64,
  input logic              halt_all,
  input logic              wr_fire,
  input logic              inhibit,
  input logic [CNT_W-1:0]  count_q
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> count_q == '0);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !inhibit) |=> count_q == $past(count_q) + ONE);

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && inhibit) |=> $stable(count_q));

  p_global_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && halt_all) |=> $stable(count_q));

  p_wr_low_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !xlen64 && csr_addr == LO_ADDR) |=>
      count_q == {$past(count_q[CNT_W-1:HALF_W]), $past(csr_wdata[HALF_W-1:0])});

  p_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && xlen64 && csr_addr == LO_ADDR) |=> count_q == $past(csr_wdata));

  p_full_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xlen64 && csr_addr == LO_ADDR) |-> (csr_hit && csr_rdata == count_q));

  p_wr_high_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !xlen64 && csr_addr == HI_ADDR) |=>
      count_q == {$past(csr_wdata[HALF_W-1:0]), $past(count_q[HALF_W-1:0])});

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr != LO_ADDR && csr_addr != HI_ADDR) |-> (!csr_hit && csr_rdata == '0 && !wr_fire));

endmodule

bind cyc_counter_csr cyc_counter_csr_chk #(
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .LO_ADDR (LO_ADDR),
  .HI_ADDR (HI_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .csr_hit   (csr_hit),
  .xlen64    (xlen64),
  .halt_all  (halt_all),
  .wr_fire   (wr_fire),
  .inhibit   (inhibit),
  .count_q   (count_q)
);

// File: tb/cyc_counter_csr_bench.sv
module cyc_counter_csr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [11:0] A_LO  = 12'hB00;
  localparam logic [11:0] A_HI  = 12'hB80;
  localparam logic [11:0] A_BAD = 12'h123;
  localparam int NVEC = 12;

  // {all, m, hs, u, vs, vu, priv[1:0], virt, counts}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b000000_11_0_1,  // M, no stop
    10'b010000_11_0_0,  // M stop in M
    10'b010000_01_0_1,  // M stop while HS
    10'b001000_01_0_0,  // HS stop in HS
    10'b001000_01_1_1,  // HS stop while VS
    10'b000100_00_0_0,  // U stop in U
    10'b000100_00_1_1,  // U stop while VU
    10'b000010_01_1_0,  // VS stop in VS
    10'b000001_00_1_0,  // VU stop in VU
    10'b000001_11_1_1,  // VU stop while M with virt set
    10'b100000_00_0_0,  // global stop
    10'b011111_10_0_1   // reserved code matches no stop bit
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic        csr_we;
  logic [63:0] csr_wdata;
  logic [63:0] csr_rdata;
  logic        csr_hit;
  logic        xlen64;
  logic [1:0]  priv;
  logic        virt;
  logic        halt_all, halt_m, halt_hs, halt_u, halt_vs, halt_vu;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_counter_csr u_cyc_counter_csr (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
    .xlen64(xlen64), .priv(priv), .virt(virt), .halt_all(halt_all),
    .halt_m(halt_m), .halt_hs(halt_hs), .halt_u(halt_u),
    .halt_vs(halt_vs), .halt_vu(halt_vu)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    csr_addr  = a;
    csr_wdata = d;
    csr_we    = 1'b1;
    tick();
    csr_we    = 1'b0;
    csr_addr  = A_LO;
  endtask

  task automatic set_halts(input logic [5:0] h);
    {halt_all, halt_m, halt_hs, halt_u, halt_vs, halt_vu} = h;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d cycles expected=fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] base;
    rst_n = 1'b0; csr_addr = A_LO; csr_we = 1'b0; csr_wdata = '0;
    xlen64 = 1'b1; priv = 2'b11; virt = 1'b0;
    set_halts(6'b100000);
    repeat (3) @(posedge clk);
    #1;
    rd(A_LO, d);
    check("R1 read during reset", d, 64'h0);
    rst_n = 1'b1;
    tick(); tick();
    rd(A_LO, d);
    check("R1 read after reset while halted", d, 64'h0);

    // Table walk over stop bits and modes (R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      base = 64'h0000_0001_0000_0000 + 64'(i) * 64'h100;
      set_halts(6'b100000);
      wr(A_LO, base);
      rd(A_LO, d);
      check("R7 full write loads base", d, base);
      set_halts(VEC[i][9:4]);
      priv = VEC[i][3:2];
      virt = VEC[i][1];
      repeat (4) tick();
      rd(A_LO, d);
      check((i == 10) ? "R4 global stop" : "R3 mode stop table",
            d, base + (VEC[i][0] ? 64'd4 : 64'd0));
    end

    // Write priority and wrap (R5, R2)
    priv = 2'b11; virt = 1'b0; set_halts(6'b000000);
    wr(A_LO, 64'h0000_0000_0000_0500);
    rd(A_LO, d);
    check("R5 no increment on write cycle", d, 64'h500);
    tick();
    rd(A_LO, d);
    check("R2 step after write", d, 64'h501);
    wr(A_LO, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_LO, d);
    check("R5 all ones loaded", d, 64'hFFFF_FFFF_FFFF_FFFF);
    tick();
    rd(A_LO, d);
    check("R2 wrap to zero", d, 64'h0);

    // Half-word access (R6, R9, R8)
    set_halts(6'b100000);
    wr(A_LO, 64'h1234_5678_9ABC_DEF0);
    xlen64 = 1'b0;
    wr(A_LO, 64'hFFFF_FFFF_1111_1111);
    rd(A_HI, d);
    check("R6 low write keeps upper word", d, 64'h0000_0000_1234_5678);
    rd(A_LO, d);
    check("R9 low read zero-extended", d, 64'h0000_0000_1111_1111);
    wr(A_HI, 64'hDEAD_BEEF_CAFE_F00D);
    rd(A_HI, d);
    check("R9 high write takes wdata low bits", d, 64'h0000_0000_CAFE_F00D);
    rd(A_LO, d);
    check("R9 high write keeps low word", d, 64'h0000_0000_1111_1111);
    xlen64 = 1'b1;
    rd(A_LO, d);
    check("R8 full read", d, 64'hCAFE_F00D_1111_1111);
    check("R8 hit on full read", {63'h0, csr_hit}, 64'h1);

    // Carry across the word boundary in 32-bit operation (R2)
    xlen64 = 1'b0;
    set_halts(6'b000000);
    wr(A_LO, 64'h0000_0000_FFFF_FFFF);
    tick();
    set_halts(6'b100000);
    rd(A_HI, d);
    check("R2 carry into upper word", d, 64'h0000_0000_CAFE_F00E);
    rd(A_LO, d);
    check("R2 low word after carry", d, 64'h0);

    // Unmapped addresses (R10)
    rd(A_BAD, d);
    check("R10 unmapped read data", d, 64'h0);
    check("R10 unmapped hit", {63'h0, csr_hit}, 64'h0);
    wr(A_BAD, 64'h5555_5555_5555_5555);
    xlen64 = 1'b1;
    rd(A_LO, d);
    check("R10 unmapped write ignored", d, 64'hCAFE_F00E_0000_0000);
    rd(A_HI, d);
    check("R10 high address unmapped in 64-bit", d, 64'h0);
    check("R10 high address hit low in 64-bit", {63'h0, csr_hit}, 64'h0);
    wr(A_HI, 64'h7777_7777_7777_7777);
    rd(A_LO, d);
    check("R10 high write ignored in 64-bit", d, 64'hCAFE_F00E_0000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule